// File: doc/BRIEF.md
# Programmable Baud Rate Generator

This block turns a stream of source clock enables into a square-wave bit clock for one serial channel. Each of its two output levels lasts a programmed number of source ticks. The 16-bit time constant arrives as two separately held bytes. A select bit chooses between a free-running system clock enable and an enable recovered from an external clock pin. The resulting output frequency is the source tick rate divided by 2·(TC+2). A later sampling divider, outside this block, divides the output by 1, 16, 32 or 64.

The count runs down from a reload value to zero. When a tick arrives at zero, the output level inverts and the counter reloads from the time constant that is present at that moment. Each inversion also raises a one-cycle event for the interrupt logic. While the count stands at zero, a status level reports it. Dropping the enable freezes the count and the output level. Raising the enable again restarts a full half period.

Top module: `baud_gen`

## Requirements
- R1: After reset, baud_out, zero_evt and zero_flag are all 0. They stay so until cnt_en is first set.
- R2: While enabled, baud_out inverts once every TC+2 selected source ticks, so its frequency is f/(2·(TC+2)). The sampled edge on which cnt_en is first seen high loads the counter and does not count as a tick.
- R3: TC is formed with tc_hi in bits 15:8 and tc_lo in bits 7:0. A time constant above 255 gives a half period of TC+2 ticks computed from both bytes.
- R4: src_sys = 1 selects sys_tick as the source and ext_tick has no effect. src_sys = 0 selects ext_tick and sys_tick has no effect.
- R5: zero_evt is high for exactly one cycle, in the same cycle in which baud_out takes its new level, and it is never high otherwise.
- R6: zero_flag is 1 from the cycle after the tick that brings the count to zero until the reload. It is 0 in the cycle of every reload and load.
- R7: Writing tc_lo or tc_hi in the middle of a half period does not change that half period. The new value sets the length of the following half period.
- R8: While cnt_en = 0, the count, baud_out and zero_flag keep their values and no zero_evt occurs. Setting cnt_en again starts a full TC+2 half period and keeps the current output level.
- R9: TC = 0 gives the shortest half period, 2 ticks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | system clock |
| rst_n | input | 1 | asynchronous active-low reset |
| tc_lo | input | 8 | time constant, low byte |
| tc_hi | input | 8 | time constant, high byte |
| cnt_en | input | 1 | 1 lets the counter run; 0 freezes it |
| src_sys | input | 1 | 1 selects sys_tick; 0 selects ext_tick |
| sys_tick | input | 1 | source enable from the system clock domain |
| ext_tick | input | 1 | source enable recovered from the external clock pin |
| baud_out | output | 1 | square-wave bit clock |
| zero_evt | output | 1 | one-cycle pulse on every count wrap |
| zero_flag | output | 1 | count is at zero |

## Verification
Four latencies matter, each counted from the sampled clock edge that causes the result. baud_out and zero_evt change one cycle after the edge that samples a tick with the count at zero. zero_flag rises one cycle after the edge that samples the tick bringing the count to zero. The edge that first sees cnt_en high only loads the counter, so the first tick counts at the following edge. The bench drives every input half a period before an edge and predicts the edge number at which each inversion falls. It pushes that number into a scoreboard queue and checks the outputs a quarter period after each edge, where all three results for that edge are already settled.

// File: rtl/brg_pkg.sv
`timescale 1ns/1ps
package brg_pkg;

  typedef enum logic {
    SRC_EXT = 1'b0,
    SRC_SYS = 1'b1
  } brg_src_e;

  // ticks spent on one output level for a given time constant
  function automatic int unsigned half_ticks(input int unsigned tc);
    return tc + 2;
  endfunction

endpackage

// File: rtl/brg_src_sel.sv
`timescale 1ns/1ps
module brg_src_sel (
  input  logic sel,
  input  logic sys_tick,
  input  logic ext_tick,
  output logic tick
);
  import brg_pkg::*;

  brg_src_e src_w;

  assign src_w = brg_src_e'(sel);

  always_comb begin
    unique case (src_w)
      SRC_SYS: tick = sys_tick;
      SRC_EXT: tick = ext_tick;
      default: tick = 1'b0;
    endcase
  end
endmodule

// File: rtl/brg_down_cnt.sv
`timescale 1ns/1ps
module brg_down_cnt #(
  parameter int TC_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic            tick,
  input  logic [TC_W-1:0] tc,
  output logic            cnt_zero,
  output logic            wrap_evt
);
  localparam int CNT_W = TC_W + 1;

  logic [CNT_W-1:0] cnt_q;
  logic             run_q;
  logic             start_w;
  logic             step_w;

  // reload value: one less than the half period, so the zero state is the last tick
  function automatic logic [CNT_W-1:0] reload_of(input logic [TC_W-1:0] t);
    int unsigned h;
    h = brg_pkg::half_ticks(32'(t));
    return CNT_W'(h - 1);
  endfunction

  assign start_w  = run && !run_q;
  assign step_w   = run && run_q && tick;
  assign cnt_zero = (cnt_q == '0);
  assign wrap_evt = step_w && cnt_zero;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '1;
      run_q <= 1'b0;
    end else begin
      run_q <= run;
      if (start_w) begin
        cnt_q <= reload_of(tc);
      end else if (step_w) begin
        if (cnt_zero) cnt_q <= reload_of(tc);
        else          cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  // R8
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> $stable(cnt_q));

  // R6
  load_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_w |=> !cnt_zero);
endmodule

// File: rtl/brg_out_stage.sv
`timescale 1ns/1ps
module brg_out_stage (
  input  logic clk,
  input  logic rst_n,
  input  logic wrap_evt,
  output logic baud,
  output logic pulse
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      baud  <= 1'b0;
      pulse <= 1'b0;
    end else begin
      pulse <= wrap_evt;
      if (wrap_evt) baud <= !baud;
    end
  end

  // R5
  pulse_with_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |-> (baud != $past(baud)));
endmodule

// File: rtl/baud_gen.sv
`timescale 1ns/1ps
module baud_gen #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BYTE_W-1:0] tc_lo,
  input  logic [BYTE_W-1:0] tc_hi,
  input  logic              cnt_en,
  input  logic              src_sys,
  input  logic              sys_tick,
  input  logic              ext_tick,
  output logic              baud_out,
  output logic              zero_evt,
  output logic              zero_flag
);
  localparam int TC_W = 2 * BYTE_W;

  logic [TC_W-1:0] tc_w;
  logic            src_tick_w;
  logic            wrap_evt_w;
  logic            cnt_zero_w;

  assign tc_w = {tc_hi, tc_lo};

  brg_src_sel u_src (
    .sel      (src_sys),
    .sys_tick (sys_tick),
    .ext_tick (ext_tick),
    .tick     (src_tick_w)
  );

  brg_down_cnt #(.TC_W(TC_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (cnt_en),
    .tick     (src_tick_w),
    .tc       (tc_w),
    .cnt_zero (cnt_zero_w),
    .wrap_evt (wrap_evt_w)
  );

  brg_out_stage u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .wrap_evt (wrap_evt_w),
    .baud     (baud_out),
    .pulse    (zero_evt)
  );

  assign zero_flag = cnt_zero_w;

  // R5
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    zero_evt |=> !zero_evt);

  // R6
  flag_clear_on_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    zero_evt |-> !zero_flag);

  // R8
  frozen_output_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_en |=> ($stable(baud_out) && !zero_evt));
endmodule

// File: tb/test_baud_gen.sv
`timescale 1ns/1ps
module test_baud_gen;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] tc_lo = '0;
  logic [7:0] tc_hi = '0;
  logic       cnt_en = 1'b0;
  logic       src_sys = 1'b1;
  logic       sys_tick = 1'b0;
  logic       ext_tick = 1'b0;
  logic       baud_out;
  logic       zero_evt;
  logic       zero_flag;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit done = 0;
  int exp_q[$];

  // reference model state
  bit    m_prev_en = 0;
  bit    m_seen = 0;
  int    m_k = 0;
  int    m_half = 2;
  bit    exp_zf = 0;
  string phase = "R1";

  baud_gen i_baud_gen (
    .clk(clk), .rst_n(rst_n), .tc_lo(tc_lo), .tc_hi(tc_hi),
    .cnt_en(cnt_en), .src_sys(src_sys), .sys_tick(sys_tick), .ext_tick(ext_tick),
    .baud_out(baud_out), .zero_evt(zero_evt), .zero_flag(zero_flag)
  );

  always #(CLK_PERIOD/2) clk = !clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d (edge %0d)", req, what, act, exp, cyc);
    end
  endtask

  // drive one edge's inputs and predict the state after that edge
  task automatic step(input bit nen, input bit st, input bit et, input logic [15:0] ntc);
    bit tk;
    @(negedge clk);
    cnt_en = nen; sys_tick = st; ext_tick = et;
    tc_lo = ntc[7:0]; tc_hi = ntc[15:8];
    tk = src_sys ? st : et;
    if (nen && !m_prev_en) begin
      m_half = int'(ntc) + 2; m_k = 0; m_seen = 1;
    end else if (nen && tk) begin
      if (m_k == m_half - 1) begin
        exp_q.push_back(cyc + 1);
        m_half = int'(ntc) + 2; m_k = 0;
      end else begin
        m_k++;
      end
    end
    m_prev_en = nen;
    exp_zf = m_seen && (m_k == m_half - 1);
  endtask

  task automatic run_sys(input int n, input logic [15:0] ntc);
    for (int i = 0; i < n; i++) step(1'b1, 1'b1, i[0], ntc);
  endtask

  task automatic run_ext(input int n, input int per, input logic [15:0] ntc);
    for (int i = 0; i < n; i++) step(1'b1, 1'b1, (i % per) == 0, ntc);
  endtask

  task automatic freeze(input int n, input logic [15:0] ntc);
    for (int i = 0; i < n; i++) step(1'b0, 1'b1, 1'b1, ntc);
  endtask

  // monitor: scoreboard of output inversions plus per-edge status checks
  initial begin
    bit prev;
    bit chg;
    int e;
    prev = 0;
    forever begin
      @(posedge clk);
      #(CLK_PERIOD/4);
      if (rst_n) begin
        chg = (baud_out != prev);
        chk(zero_evt == chg, "R5", "zero_evt vs output change", zero_evt, chg);
        chk(zero_flag == exp_zf, "R6", "zero_flag", zero_flag, exp_zf);
        if (chg) begin
          if (exp_q.size() == 0) begin
            chk(1'b0, phase, "unexpected output inversion at edge", cyc, -1);
          end else begin
            e = exp_q.pop_front();
            chk(e == cyc, phase, "inversion edge", cyc, e);
          end
        end
        prev = baud_out;
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1;
      bad++; total++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    freeze(3, 16'd0);
    @(posedge clk); #(CLK_PERIOD/4);
    chk(baud_out == 1'b0, "R1", "baud_out after reset", baud_out, 0);
    chk(zero_evt == 1'b0, "R1", "zero_evt after reset", zero_evt, 0);
    chk(zero_flag == 1'b0, "R1", "zero_flag after reset", zero_flag, 0);

    phase = "R9"; run_sys(20, 16'd0);      freeze(3, 16'd0);
    phase = "R2"; run_sys(60, 16'd5);      freeze(3, 16'd5);
    phase = "R3"; run_sys(1100, 16'h0102); freeze(3, 16'h0102);
    src_sys = 1'b0;
    phase = "R4"; run_ext(90, 3, 16'd3);   freeze(2, 16'd3);
    phase = "R9"; run_ext(30, 2, 16'd0);   freeze(2, 16'd0);
    src_sys = 1'b1;
    phase = "R7"; run_sys(5, 16'd10); run_sys(60, 16'd2); freeze(3, 16'd2);
    phase = "R8"; run_sys(10, 16'd4); freeze(9, 16'd4); run_sys(30, 16'd4);
    freeze(4, 16'd4);

    chk(exp_q.size() == 0, "R2", "missing inversions", exp_q.size(), 0);
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule